// File: doc/BRIEF.md
# Narrow-Bus FIFO Write Assembler

This block builds wide FIFO entries out of 16-bit register-bus writes. Software first picks one of three destination banks through a command register. Two of the banks take 48-bit entries. The third takes 32-bit entries. The choice stays in force for any number of following entries.

For each entry, software writes the 16-bit slices into a small group of part registers. It then writes a push code to a strobe register. The block forwards the assembled word, tagged with a bank code, as a single-cycle push toward the storage, which lives outside the block.

A mode register gates the data path. Until bus access is enabled there, part and strobe writes are discarded. The storage reports a full flag per bank. A push aimed at a full bank is dropped, and a sticky overflow flag records the loss.

Top module: `narrow_push_assembler`

## Requirements
- R1: After reset, push_valid is 0, and the command register (offset 0x90), the mode register (offset 0x91) and all part registers read 0.
- R2: While mode register bit 0 is 0, writes to the part registers (0x94..0x96) and to the strobe register (0x97) have no effect; the command and mode registers stay writable.
- R3: Command register bits [1:0] select the bank: 0 is bank A, 1 is bank B, 2 is bank C. The selection holds across any number of pushes until it is rewritten. Code 3 selects no bank, and strobes then push nothing.
- R4: For the 48-bit banks A and B, offset 0x94 supplies push_data[15:0], 0x95 supplies [31:16] and 0x96 supplies [47:32]; each part register reads back what was last written.
- R5: For bank C, push_data is {16'h0000, part 0x95, part 0x94}; the content of 0x96 does not reach the push.
- R6: Writing the value 1 to offset 0x97 raises push_valid in the cycle after the write, with push_bank equal to the selected code and push_data assembled as in R4/R5.
- R7: Writing any value other than 1 to offset 0x97 causes no push.
- R8: A strobe while bank_full[selected bank] is 1 is dropped and sets command register bit 4. This bit stays set until a command write with bit 4 equal to 1 clears it.
- R9: Part registers keep their contents after a push.
- R10: Each accepted strobe produces push_valid for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| bank_full | input | 3 | Per-bank full flags from the storage |
| push_valid | output | 1 | One-cycle push pulse |
| push_data | output | 48 | Assembled entry |
| push_bank | output | 2 | Destination bank code |

## Verification
The hardest condition to reach is an overflow that must persist. It needs a strobe aimed at a bank whose full flag is raised, followed by a later successful push that must leave the flag set. The stimulus reaches this by raising bank_full for the selected bank before the strobe. It then reads the command register, drops the full flag, and pushes again. Only after that does it clear the flag with a write-one. Bank C's ignored top slice is exercised by table rows that load 0x96 with a non-zero pattern before a bank C push.

// File: rtl/npa_pkg.sv
package npa_pkg;
  typedef enum logic [1:0] {
    BANK_A    = 2'd0,
    BANK_B    = 2'd1,
    BANK_C    = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  localparam int unsigned NARROW_PARTS = 2;
endpackage

// File: rtl/npa_part_regs.sv
module npa_part_regs #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NPART = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPART-1:0]      part_we,
  input  logic [DW-1:0]         wdata,
  output logic [NPART*DW-1:0]   parts
);
  for (genvar i = 0; i < NPART; i++) begin : g_part
    logic [DW-1:0] slice_q;
    logic [DW-1:0] slice_d;

    always_comb begin
      slice_d = slice_q;
      if (part_we[i]) slice_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slice_q <= '0;
      else if (part_we[i]) slice_q <= slice_d;
    end

    assign parts[i*DW +: DW] = slice_q;
  end
endmodule

// File: rtl/npa_ctrl_regs.sv
module npa_ctrl_regs #(
  parameter int unsigned DW      = 16,
  parameter int unsigned OVF_BIT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_we,
  input  logic           mode_we,
  input  logic [DW-1:0]  wdata,
  input  logic           drop,
  output npa_pkg::bank_e sel_q,
  output logic           mode_q,
  output logic           ovf_q
);
  import npa_pkg::*;

  bank_e sel_d;
  logic  mode_d;
  logic  ovf_d;

  always_comb begin
    sel_d  = sel_q;
    mode_d = mode_q;
    ovf_d  = ovf_q;
    if (cmd_we) begin
      sel_d = bank_e'(wdata[1:0]);
      if (wdata[OVF_BIT]) ovf_d = 1'b0;
    end
    if (mode_we) mode_d = wdata[0];
    if (drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= BANK_A;
      mode_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      mode_q <= mode_d;
      ovf_q  <= ovf_d;
    end
  end
endmodule

// File: rtl/npa_push_stage.sv
module npa_push_stage #(
  parameter int unsigned DW    = 16,
  parameter int unsigned NPART = 3,
  parameter int unsigned NBANK = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stb,
  input  npa_pkg::bank_e       sel,
  input  logic [NBANK-1:0]     bank_full,
  input  logic [NPART*DW-1:0]  parts,
  output logic                 drop,
  output logic                 push_valid,
  output logic [NPART*DW-1:0]  push_data,
  output logic [1:0]           push_bank
);
  import npa_pkg::*;

  localparam int unsigned EW = NPART * DW;

  logic          sel_ok;
  logic          sel_full;
  logic          fire;
  logic [EW-1:0] entry;
  logic          valid_d;

  always_comb begin
    sel_full = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel == bank_e'(b)) sel_full = bank_full[b];
    end
    sel_ok = (sel != BANK_NONE);
    fire   = stb && sel_ok && !sel_full;
    drop   = stb && sel_ok && sel_full;
  end

  for (genvar i = 0; i < NPART; i++) begin : g_mask
    if (i < NARROW_PARTS) begin : g_keep
      assign entry[i*DW +: DW] = parts[i*DW +: DW];
    end else begin : g_wide
      assign entry[i*DW +: DW] = (sel == BANK_C) ? '0 : parts[i*DW +: DW];
    end
  end

  assign valid_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_valid <= 1'b0;
    else        push_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_data <= '0;
      push_bank <= '0;
    end else if (fire) begin
      push_data <= entry;
      push_bank <= sel;
    end
  end
endmodule

// File: rtl/narrow_push_assembler.sv
module narrow_push_assembler #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter int unsigned NPART    = 3,
  parameter int unsigned NBANK    = 3,
  parameter logic [7:0]  CMD_OFS  = 8'h90,
  parameter logic [7:0]  MODE_OFS = 8'h91,
  parameter logic [7:0]  PART_OFS = 8'h94,
  parameter logic [7:0]  STB_OFS  = 8'h97,
  parameter int unsigned STB_CODE = 1,
  parameter int unsigned OVF_BIT  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NBANK-1:0]     bank_full,
  output logic                 push_valid,
  output logic [NPART*DW-1:0]  push_data,
  output logic [1:0]           push_bank
);
  import npa_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  bank_e              sel_q;
  logic               mode_q;
  logic               ovf_q;
  logic               drop;
  logic               cmd_we;
  logic               mode_we;
  logic               stb;
  logic [NPART-1:0]   part_we;
  logic [NPART*DW-1:0] parts;

  always_comb begin
    cmd_we  = bus_wr && (bus_addr == AW'(CMD_OFS));
    mode_we = bus_wr && (bus_addr == AW'(MODE_OFS));
    stb     = bus_wr && mode_q && (bus_addr == AW'(STB_OFS)) &&
              (bus_wdata == DW'(STB_CODE));
    for (int i = 0; i < NPART; i++) begin
      part_we[i] = bus_wr && mode_q && (bus_addr == AW'(PART_OFS + 8'(i)));
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(CMD_OFS)) begin
      bus_rdata[1:0]     = sel_q;
      bus_rdata[OVF_BIT] = ovf_q;
    end else if (bus_addr == AW'(MODE_OFS)) begin
      bus_rdata[0] = mode_q;
    end
    for (int i = 0; i < NPART; i++) begin
      if (bus_addr == AW'(PART_OFS + 8'(i))) bus_rdata = parts[i*DW +: DW];
    end
  end

  npa_ctrl_regs #(.DW(DW), .OVF_BIT(OVF_BIT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd_we  (cmd_we),
    .mode_we (mode_we),
    .wdata   (bus_wdata),
    .drop    (drop),
    .sel_q   (sel_q),
    .mode_q  (mode_q),
    .ovf_q   (ovf_q)
  );

  npa_part_regs #(.DW(DW), .NPART(NPART)) u_parts (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .part_we (part_we),
    .wdata   (bus_wdata),
    .parts   (parts)
  );

  npa_push_stage #(.DW(DW), .NPART(NPART), .NBANK(NBANK)) u_push (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stb        (stb),
    .sel        (sel_q),
    .bank_full  (bank_full),
    .parts      (parts),
    .drop       (drop),
    .push_valid (push_valid),
    .push_data  (push_data),
    .push_bank  (push_bank)
  );
endmodule

// File: rtl/npa_checker.sv
module npa_checker #(
  parameter int unsigned DW       = 16,
  parameter int unsigned AW       = 8,
  parameter int unsigned NPART    = 3,
  parameter int unsigned NBANK    = 3,
  parameter logic [7:0]  CMD_OFS  = 8'h90,
  parameter logic [7:0]  STB_OFS  = 8'h97,
  parameter int unsigned STB_CODE = 1,
  parameter int unsigned OVF_BIT  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic [AW-1:0]       bus_addr,
  input logic [DW-1:0]       bus_wdata,
  input logic [NBANK-1:0]    bank_full,
  input logic                push_valid,
  input logic [NPART*DW-1:0] push_data,
  input logic [1:0]          push_bank,
  input logic [1:0]          sel_q,
  input logic                mode_q,
  input logic                ovf_q
);
  logic sel_full;
  logic stb_seen;
  logic ovf_clear;

  always_comb begin
    sel_full = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (sel_q == 2'(b)) sel_full = bank_full[b];
    end
    stb_seen  = bus_wr && mode_q && (bus_addr == AW'(STB_OFS)) &&
                (bus_wdata == DW'(STB_CODE));
    ovf_clear = bus_wr && (bus_addr == AW'(CMD_OFS)) && bus_wdata[OVF_BIT];
  end

  p_push_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> $past(stb_seen));

  p_no_push_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !$past(sel_full));

  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !ovf_clear |=> ovf_q);

  p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !mode_q |=> !push_valid);

  p_bank_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_bank != 2'd3);

  p_narrow_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_bank == 2'd2 |-> push_data[NPART*DW-1:2*DW] == '0);
endmodule

bind narrow_push_assembler npa_checker #(
  .DW(DW), .AW(AW), .NPART(NPART), .NBANK(NBANK),
  .CMD_OFS(CMD_OFS), .STB_OFS(STB_OFS), .STB_CODE(STB_CODE), .OVF_BIT(OVF_BIT)
) u_npa_checker (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bank_full  (bank_full),
  .push_valid (push_valid),
  .push_data  (push_data),
  .push_bank  (push_bank),
  .sel_q      (sel_q),
  .mode_q     (mode_q),
  .ovf_q      (ovf_q)
);

// File: tb/narrow_push_assembler_tb_top.sv
module narrow_push_assembler_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [2:0]  bank_full;
  logic        push_valid;
  logic [47:0] push_data;
  logic [1:0]  push_bank;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  narrow_push_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_full(bank_full),
    .push_valid(push_valid), .push_data(push_data), .push_bank(push_bank)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {sel[1:0], high, mid, low, expected push_data}
  localparam int NVEC = 6;
  localparam logic [97:0] VEC [NVEC] = '{
    {2'd0, 16'hAAAA, 16'h5555, 16'h1234, 48'hAAAA_5555_1234},
    {2'd1, 16'h0F0F, 16'hF0F0, 16'hBEEF, 48'h0F0F_F0F0_BEEF},
    {2'd2, 16'hDEAD, 16'hCAFE, 16'h0001, 48'h0000_CAFE_0001},
    {2'd0, 16'hFFFF, 16'h0000, 16'hFFFF, 48'hFFFF_0000_FFFF},
    {2'd2, 16'h7777, 16'h8001, 16'h8000, 48'h0000_8001_8000},
    {2'd1, 16'h0001, 16'h0002, 16'h0003, 48'h0001_0002_0003}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic no_push_next(input string req);
    @(negedge clk);
    #1 chk(push_valid == 1'b0, req, 64'(push_valid), 64'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; bank_full = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1 chk(push_valid == 1'b0, "R1 push_valid", 64'(push_valid), 0);
    rd(8'h90, r); chk(r == 16'h0, "R1 cmd", 64'(r), 0);
    rd(8'h91, r); chk(r == 16'h0, "R1 mode", 64'(r), 0);
    rd(8'h94, r); chk(r == 16'h0, "R1 part", 64'(r), 0);

    // R2 gate closed
    wr(8'h94, 16'h1234);
    rd(8'h94, r); chk(r == 16'h0, "R2 part write ignored", 64'(r), 0);
    wr(8'h90, 16'h0000);
    wr(8'h97, 16'h0001);
    chk(push_valid == 1'b0, "R2 strobe ignored", 64'(push_valid), 0);
    wr(8'h91, 16'h0001);
    rd(8'h91, r); chk(r == 16'h1, "R2 mode enabled", 64'(r), 1);

    // R4 R5 R6 R10 table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h90, {14'd0, VEC[i][97:96]});
      wr(8'h94, VEC[i][63:48]);
      wr(8'h95, VEC[i][79:64]);
      wr(8'h96, VEC[i][95:80]);
      wr(8'h97, 16'h0001);
      chk(push_valid == 1'b1, "R6 push pulse", 64'(push_valid), 1);
      chk(push_data == VEC[i][47:0], "R4/R5 push data", 64'(push_data), 64'(VEC[i][47:0]));
      chk(push_bank == VEC[i][97:96], "R6 push bank", 64'(push_bank), 64'(VEC[i][97:96]));
      no_push_next("R10 single cycle");
    end

    // R9 retention after push
    rd(8'h94, r); chk(r == 16'h0003, "R9 low kept", 64'(r), 3);
    rd(8'h96, r); chk(r == 16'h0001, "R9 high kept", 64'(r), 1);
    rd(8'h95, r); chk(r == 16'h0002, "R4 mid readback", 64'(r), 2);

    // R3 select persists; code 3 blocks
    wr(8'h90, 16'h0001);
    wr(8'h97, 16'h0001);
    chk(push_bank == 2'd1 && push_valid, "R3 first push bank B", 64'(push_bank), 1);
    wr(8'h94, 16'h4444);
    wr(8'h97, 16'h0001);
    chk(push_bank == 2'd1 && push_valid, "R3 bank persists", 64'(push_bank), 1);
    chk(push_data == 48'h0001_0002_4444, "R9 repush uses kept parts", 64'(push_data), 64'h000100024444);
    wr(8'h90, 16'h0003);
    wr(8'h97, 16'h0001);
    chk(push_valid == 1'b0, "R3 code 3 no push", 64'(push_valid), 0);

    // R7 other strobe values
    wr(8'h90, 16'h0000);
    wr(8'h97, 16'h0002);
    chk(push_valid == 1'b0, "R7 value 2", 64'(push_valid), 0);
    wr(8'h97, 16'h0003);
    chk(push_valid == 1'b0, "R7 value 3", 64'(push_valid), 0);
    wr(8'h97, 16'h0000);
    chk(push_valid == 1'b0, "R7 value 0", 64'(push_valid), 0);

    // R8 full drop, sticky overflow, clear
    rd(8'h90, r); chk(r[4] == 1'b0, "R8 overflow clear before", 64'(r), 0);
    bank_full = 3'b001;
    wr(8'h97, 16'h0001);
    chk(push_valid == 1'b0, "R8 dropped when full", 64'(push_valid), 0);
    rd(8'h90, r); chk(r[4] == 1'b1, "R8 overflow set", 64'(r), 16'h10);
    bank_full = 3'b110;
    wr(8'h97, 16'h0001);
    chk(push_valid == 1'b1, "R8 push to non-full bank", 64'(push_valid), 1);
    rd(8'h90, r); chk(r[4] == 1'b1, "R8 overflow sticky", 64'(r), 16'h10);
    wr(8'h90, 16'h0012);
    rd(8'h90, r); chk(r == 16'h0002, "R8 overflow cleared", 64'(r), 2);
    wr(8'h97, 16'h0001);
    chk(push_valid == 1'b0, "R8 bank C full dropped", 64'(push_valid), 0);
    bank_full = 3'b000;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule